// File: doc/BRIEF.md
# Floating-Point Error Reporting Controller

This block turns unmasked floating-point exception events into the two ways a processor can report them: an external error pin level, and an internal numeric-error trap request that is held back until the next instruction able to take it. A control bit selects native trap reporting. When that bit is clear, an ignore-error input chooses whether errors go out on the pin or are dropped.

The block also decides, cycle by cycle, whether the error pin driver is enabled. The driver is switched off in the parked power states and while processor reset, processor init or the debug-probe ready signal is active. It can optionally include a model of the motherboard busy latch. That latch converts a driven error level into interrupt request line 13 and is cleared only by a write strobe to its port.

Top module: `fp_err_report`

## Requirements
- R1: With `ne_ctl_i`=1, a cycle in which any bit of `fp_exc_i` is set makes `ferr_o` 1 after the next clock edge and leaves a numeric-error trap pending.
- R2: A pending trap is taken only when `insn_class_i` is 1 (wait) or 2 (computational FP); codes 0 (none) and 3 (other) leave it pending. Taking it gives a one-cycle `numerr_req_o` pulse one edge after the strobe, with `numerr_vec_o`=16; `numerr_vec_o` is 0 in every other cycle.
- R3: With `ne_ctl_i`=1, the level of `ignne_i` changes neither the pin nor the trap behaviour.
- R4: With `ne_ctl_i`=0 and `ignne_i`=0, an error sets `ferr_o` but never causes `numerr_req_o`.
- R5: With `ne_ctl_i`=0 and `ignne_i`=1, an error is dropped: `ferr_o` stays 0 and no trap becomes pending.
- R6: `irq13_o` becomes 1 one edge after a cycle in which `ferr_o` and `ferr_oe_o` are both 1. It then holds until `latch_wr_clr_i`, which wins over a set in the same cycle.
- R7: `ferr_oe_o` is 0 one edge after a cycle in which `pwr_state_i` is 1 (halt), 2 (shutdown), 3 (stop grant) or 4 (stop clock), or in which `cpu_reset_i`, `cpu_init_i` or `probe_rdy_i` is 1.
- R8: `ferr_oe_o` is 1 one edge after any other cycle, including `pwr_state_i` 0 (run), 5 (system management) and 6 or 7.
- R9: `ferr_o` holds until `err_clear_i`, which also cancels a pending trap. A new error in the same cycle as the clear takes effect instead of the clear.
- R10: `cpu_reset_i` or `cpu_init_i` clears `ferr_o` and any pending trap.
- R11: An error arriving in the same cycle as a qualifying strobe does not trap on that strobe; it is taken at the next qualifying strobe.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| fp_exc_i | input | SRC_N | One-cycle pulses, one per unmasked exception source |
| ne_ctl_i | input | 1 | Native trap reporting enable |
| ignne_i | input | 1 | Ignore-numeric-error input |
| insn_class_i | input | 2 | Instruction class: 0 none, 1 wait, 2 computational FP, 3 other |
| err_clear_i | input | 1 | Exception-clear strobe |
| latch_wr_clr_i | input | 1 | Write strobe to the busy-latch port |
| pwr_state_i | input | 3 | Power state: 0 run, 1 halt, 2 shutdown, 3 stop grant, 4 stop clock, 5 system management |
| cpu_reset_i | input | 1 | Processor reset active |
| cpu_init_i | input | 1 | Processor init active |
| probe_rdy_i | input | 1 | Debug-probe ready active |
| ferr_o | output | 1 | Error pin level |
| ferr_oe_o | output | 1 | Error pin driver enable |
| numerr_req_o | output | 1 | Numeric-error trap request pulse |
| numerr_vec_o | output | VEC_W | Trap vector while the request is active, else 0 |
| irq13_o | output | 1 | Busy-latch interrupt request |

## Verification
The bench builds the block with SRC_N=4 and with the busy latch included, keeping VEC_W=8 and vector 16. The narrow source width lets one directed case pulse only the top source bit, which checks that every bit counts as an error. With the latch present, the interaction of the latch with the driver enable can be observed at the ports: the pin held high while parked must not raise the interrupt, and it does so only once the driver is enabled again.

// File: rtl/fperr_pkg.sv
package fperr_pkg;

    localparam int PSTATE_W = 3;

    typedef enum logic [1:0] {
        INSN_NONE   = 2'd0,
        INSN_WAIT   = 2'd1,
        INSN_FPCOMP = 2'd2,
        INSN_OTHER  = 2'd3
    } insn_cls_e;

    typedef enum logic [PSTATE_W-1:0] {
        PS_RUN       = 3'd0,
        PS_HALT      = 3'd1,
        PS_SHUTDOWN  = 3'd2,
        PS_STOPGRANT = 3'd3,
        PS_STOPCLK   = 3'd4,
        PS_SMM       = 3'd5
    } pstate_e;

    typedef struct packed {
        logic ferr;
        logic pend;
        logic req;
    } core_st_t;

endpackage

// File: rtl/fperr_core.sv
module fperr_core
    import fperr_pkg::*;
#(
    parameter int SRC_N      = 8,
    parameter int VEC_W      = 8,
    parameter int NUMERR_VEC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] exc_i,
    input  logic             ne_i,
    input  logic             ignne_i,
    input  insn_cls_e        insn_i,
    input  logic             err_clr_i,
    input  logic             sys_clr_i,
    output logic             ferr_o,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o
);

    localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(NUMERR_VEC);

    core_st_t st_d, st_q;
    logic     err_seen;
    logic     accept;
    logic     defer;
    logic     qual;

    always_comb begin
        st_d     = st_q;
        err_seen = |exc_i;
        accept   = err_seen && (ne_i || !ignne_i);
        defer    = err_seen && ne_i;
        qual     = (insn_i == INSN_WAIT) || (insn_i == INSN_FPCOMP);

        st_d.req = st_q.pend && qual && !sys_clr_i;
        if (sys_clr_i) begin
            st_d.ferr = 1'b0;
            st_d.pend = 1'b0;
        end else begin
            st_d.ferr = (st_q.ferr && !err_clr_i) || accept;
            st_d.pend = (st_q.pend && !qual && !err_clr_i) || defer;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ferr_o = st_q.ferr;
    assign req_o  = st_q.req;
    assign vec_o  = st_q.req ? VEC_VAL : '0;

    // R5
    ignored_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ne_i && ignne_i && !st_q.ferr) |=> !st_q.ferr && !st_q.pend || $past(st_q.pend));

    // R10
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clr_i |=> !st_q.ferr && !st_q.pend && !st_q.req);

    // R2
    req_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> ($past(insn_i) == INSN_WAIT) || ($past(insn_i) == INSN_FPCOMP));

    // R9
    ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ferr && !err_clr_i && !sys_clr_i) |=> st_q.ferr);

endmodule

// File: rtl/fperr_drive.sv
module fperr_drive
    import fperr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PSTATE_W-1:0] pstate_i,
    input  logic                hard_rst_i,
    input  logic                init_i,
    input  logic                probe_rdy_i,
    output logic                oe_o
);

    logic oe_d, oe_q;
    logic parked;

    always_comb begin
        parked = (pstate_i == PS_HALT)      || (pstate_i == PS_SHUTDOWN) ||
                 (pstate_i == PS_STOPGRANT) || (pstate_i == PS_STOPCLK);
        oe_d   = !(parked || hard_rst_i || init_i || probe_rdy_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_d;
    end

    assign oe_o = oe_q;

    // R7
    drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_rst_i || init_i || probe_rdy_i || pstate_i == PS_HALT ||
         pstate_i == PS_STOPCLK) |=> !oe_q);

endmodule

// File: rtl/fperr_busy_latch.sv
module fperr_busy_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ferr_i,
    input  logic oe_i,
    input  logic clr_i,
    output logic irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        if (clr_i) irq_d = 1'b0;
        else       irq_d = irq_q || (ferr_i && oe_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr_i) |=> irq_q);

    // R6
    latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !irq_q);

endmodule

// File: rtl/fp_err_report.sv
module fp_err_report
    import fperr_pkg::*;
#(
    parameter int SRC_N        = 8,
    parameter int VEC_W        = 8,
    parameter int NUMERR_VEC   = 16,
    parameter bit HAS_ATLATCH  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] fp_exc_i,
    input  logic             ne_ctl_i,
    input  logic             ignne_i,
    input  logic [1:0]       insn_class_i,
    input  logic             err_clear_i,
    input  logic             latch_wr_clr_i,
    input  logic [2:0]       pwr_state_i,
    input  logic             cpu_reset_i,
    input  logic             cpu_init_i,
    input  logic             probe_rdy_i,
    output logic             ferr_o,
    output logic             ferr_oe_o,
    output logic             numerr_req_o,
    output logic [VEC_W-1:0] numerr_vec_o,
    output logic             irq13_o
);

    logic sys_clr;
    logic ferr_lvl;
    logic oe;

    assign sys_clr = cpu_reset_i || cpu_init_i;

    fperr_core #(
        .SRC_N      (SRC_N),
        .VEC_W      (VEC_W),
        .NUMERR_VEC (NUMERR_VEC)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_i     (fp_exc_i),
        .ne_i      (ne_ctl_i),
        .ignne_i   (ignne_i),
        .insn_i    (insn_cls_e'(insn_class_i)),
        .err_clr_i (err_clear_i),
        .sys_clr_i (sys_clr),
        .ferr_o    (ferr_lvl),
        .req_o     (numerr_req_o),
        .vec_o     (numerr_vec_o)
    );

    fperr_drive u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .pstate_i    (pwr_state_i),
        .hard_rst_i  (cpu_reset_i),
        .init_i      (cpu_init_i),
        .probe_rdy_i (probe_rdy_i),
        .oe_o        (oe)
    );

    generate
        if (HAS_ATLATCH) begin : g_latch
            fperr_busy_latch u_latch (
                .clk   (clk),
                .rst_n (rst_n),
                .ferr_i(ferr_lvl),
                .oe_i  (oe),
                .clr_i (latch_wr_clr_i),
                .irq_o (irq13_o)
            );
        end else begin : g_no_latch
            assign irq13_o = 1'b0;
        end
    endgenerate

    assign ferr_o    = ferr_lvl;
    assign ferr_oe_o = oe;

    // R4
    no_trap_nat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ne_ctl_i && !numerr_req_o && insn_class_i == 2'd0) |=> !numerr_req_o);

endmodule

// File: tb/fp_err_report_tb.sv
module fp_err_report_tb;

    localparam int SRC_N = 4;
    localparam int VEC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SRC_N-1:0] fp_exc = '0;
    logic             ne_ctl = 1'b0, ignne = 1'b0;
    logic [1:0]       insn = 2'd0;
    logic             eclr = 1'b0, lclr = 1'b0;
    logic [2:0]       pwr = 3'd0;
    logic             crst = 1'b0, cinit = 1'b0, prdy = 1'b0;
    logic             ferr, oe, req, irq;
    logic [VEC_W-1:0] vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fp_err_report #(
        .SRC_N       (SRC_N),
        .VEC_W       (VEC_W),
        .NUMERR_VEC  (16),
        .HAS_ATLATCH (1'b1)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fp_exc_i       (fp_exc),
        .ne_ctl_i       (ne_ctl),
        .ignne_i        (ignne),
        .insn_class_i   (insn),
        .err_clear_i    (eclr),
        .latch_wr_clr_i (lclr),
        .pwr_state_i    (pwr),
        .cpu_reset_i    (crst),
        .cpu_init_i     (cpu_init_sig()),
        .probe_rdy_i    (prdy),
        .ferr_o         (ferr),
        .ferr_oe_o      (oe),
        .numerr_req_o   (req),
        .numerr_vec_o   (vec),
        .irq13_o        (irq)
    );

    function automatic logic cpu_init_sig();
        return cinit;
    endfunction

    typedef struct packed {
        logic       ne;
        logic       ig;
        logic       exc;
        logic [1:0] insn;
        logic       eclr;
        logic       lclr;
        logic [2:0] pwr;
        logic       crst;
        logic       cinit;
        logic       prdy;
        logic       e_ferr;
        logic       e_oe;
        logic       e_req;
        logic       e_irq;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 40;
    // fields: ne ig exc insn eclr lclr pwr crst cinit prdy | ferr oe req irq | requirement
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd8 },  // R8 idle
        '{1'b1,1'b0,1'b1,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd1 },  // R1 error
        '{1'b0,1'b0,1'b0,2'd3,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 4'd2 },  // R2 other
        '{1'b0,1'b0,1'b0,2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1, 4'd2 },  // R2 wait
        '{1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 4'd2 },  // R2 consumed
        '{1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd9 },  // R9 R6 clears
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd6 },  // R6
        '{1'b1,1'b1,1'b1,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd3 },  // R3
        '{1'b1,1'b1,1'b0,2'd2,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1, 4'd3 },  // R3
        '{1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd6 },  // R6 hold
        '{1'b0,1'b1,1'b1,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd5 },  // R5
        '{1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd5 },  // R5
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd6 },  // R6 clear
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4 },  // R4
        '{1'b0,1'b0,1'b0,2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 4'd4 },  // R4
        '{1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 4'd9 },  // R9 error wins
        '{1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd9 },  // R9
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd6 },  // R6
        '{1'b1,1'b0,1'b1,2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd11},  // R11
        '{1'b0,1'b0,1'b0,2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1, 4'd11},  // R11
        '{1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 4'd9 },  // R9
        '{1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd9 },  // R9 cancels
        '{1'b0,1'b0,1'b0,2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd9 },  // R9 no trap
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd7 },  // R7 halt
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd2,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd7 },  // R7
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd3,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd7 },  // R7
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd4,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd7 },  // R7
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd5,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd8 },  // R8 smm
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd7,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd8 },  // R8
        '{1'b1,1'b0,1'b1,2'd0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd6 },  // R6
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd6 },  // R6 parked
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd6 },  // R6
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 4'd6 },  // R6 set
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd10},  // R10 reset
        '{1'b0,1'b0,1'b0,2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd10},  // R10
        '{1'b1,1'b0,1'b1,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 4'd1 },  // R1
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd10},  // R10 init
        '{1'b0,1'b0,1'b0,2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd10},  // R10
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b1, 4'd7 },  // R7 probe
        '{1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd8 }   // R8
    };

    task automatic check(input string what, input int rq,
                         input logic [3:0] act, input logic [3:0] exp_v,
                         input logic [VEC_W-1:0] act_vec, input logic [VEC_W-1:0] exp_vec);
        checks++;
        if (act !== exp_v || act_vec !== exp_vec) begin
            errors++;
            $display("FAIL R%0d %s: ferr/oe/req/irq=%b vec=%0d expected %b vec=%0d",
                     rq, what, act, act_vec, exp_v, exp_vec);
        end
    endtask

    task automatic idle_inputs();
        fp_exc = '0; ne_ctl = 0; ignne = 0; insn = 2'd0; eclr = 0; lclr = 0;
        pwr = 3'd0; crst = 0; cinit = 0; prdy = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        // R12 outputs during block reset
        check("reset state", 12, {ferr, oe, req, irq}, 4'b0000, vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("first cycle after reset", 12, {ferr, oe, req, irq}, 4'b0100, vec, '0);

        for (int i = 0; i < NV; i++) begin
            fp_exc = TBL[i].exc ? 4'b0001 : 4'b0000;
            ne_ctl = TBL[i].ne;    ignne = TBL[i].ig;   insn = TBL[i].insn;
            eclr   = TBL[i].eclr;  lclr  = TBL[i].lclr; pwr  = TBL[i].pwr;
            crst   = TBL[i].crst;  cinit = TBL[i].cinit; prdy = TBL[i].prdy;
            @(negedge clk);
            check($sformatf("table row %0d", i), int'(TBL[i].tag), {ferr, oe, req, irq},
                  {TBL[i].e_ferr, TBL[i].e_oe, TBL[i].e_req, TBL[i].e_irq},
                  vec, TBL[i].e_req ? 8'd16 : 8'd0);
        end

        // R1 highest source bit alone counts as an error
        idle_inputs();
        ne_ctl = 1; fp_exc = 4'b1000;
        @(negedge clk);
        check("top source bit", 1, {ferr, oe, req, irq}, 4'b1101, vec, '0);
        idle_inputs();
        insn = 2'd1;
        @(negedge clk);
        check("top source trap", 1, {ferr, oe, req, irq}, 4'b1111, vec, 8'd16);
        idle_inputs();
        @(negedge clk);
        // R2 request lasts one cycle only
        check("request pulse width", 2, {ferr, oe, req, irq}, 4'b1101, vec, '0);

        // R12 block reset mid-run
        rst_n = 1'b0;
        #1;
        check("async block reset", 12, {ferr, oe, req, irq}, 4'b0000, vec, '0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule